// File: doc/BRIEF.md
# Event-Driven Auto-Mute Gain Sequencer

This block belongs to one channel of a converter datapath. It produces the digital gain word that a downstream multiplier applies to the sample stream. It has eight mute-event sources. One is a software request that the host sets and clears. The other seven are external fault and alarm lines, such as clock monitors, a temperature alarm, a data-invalid flag and a level detector. Each source has its own mask bit. An unmasked event, with the feature enabled, starts a muting sequence.

The sequencer has four states. IDLE passes the programmed initial gain. MUTE lowers the gain by a programmed step on each prescaler tick until it reaches zero. WAIT holds zero for a programmed number of cycles and stays there while any unmasked event remains high. DEMUTE raises the gain by the same step until it is back at the initial value.

The transitions are:
- IDLE to MUTE when any unmasked event is high.
- MUTE to WAIT when the gain reaches zero.
- WAIT to DEMUTE when the hold time has passed and no unmasked event is high.
- DEMUTE to IDLE when the gain reaches the initial value.
- DEMUTE to MUTE when an event appears. The ramp down then continues from the present gain.
- Any state to IDLE when the enable is cleared.

A sticky cause vector records which events started the most recent mute.

Top module: `automute_ctrl`

## Requirements
- R1: With `cfg_enable` low the state is IDLE and `gain_out` equals `cfg_init_gain` whatever the events do. Clearing `cfg_enable` in any other state returns the block to IDLE one clock later.
- R2: The event vector has the software request at bit 0 and `ext_evt[i]` at bit i+1. The trigger is the OR of the events whose `cfg_evt_mask` bit is 0; a mask bit of 1 ignores that event.
- R3: In IDLE `gain_out` equals `cfg_init_gain`. With the enable set and the trigger high, the state is MUTE after the next clock and the gain starts from `cfg_init_gain`.
- R4: In MUTE each prescaler tick lowers the gain by `cfg_step`, saturating at zero. The clock that brings the gain to zero also moves the state to WAIT.
- R5: In WAIT the gain is zero. The block stays at least `cfg_wait`+1 cycles and leaves for DEMUTE on the first clock after that at which the trigger is low.
- R6: In DEMUTE each tick raises the gain by `cfg_step`, saturating at `cfg_init_gain`. The clock that reaches the initial value moves the state to IDLE.
- R7: A trigger seen in DEMUTE moves the state to MUTE at the next clock with the gain unchanged; it has priority over a tick in that cycle.
- R8: The prescaler ticks every `cfg_presc`+1 cycles and runs freely from reset.
- R9: `sw_set` sets the software request and `sw_clr` clears it, with set winning. The request takes part in the trigger from the clock after the pulse.
- R10: On every entry to MUTE, `cause_out` loads the unmasked active events and holds them until the next entry. It is zero after reset.
- R11: `state_out` codes IDLE=0, MUTE=1, WAIT=2, DEMUTE=3.
- R12: After reset the state is IDLE, `cause_out` is zero, the software request is clear and `gain_out` equals `cfg_init_gain`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Auto-mute enable |
| cfg_evt_mask | input | NUM_EVT | Per-event ignore bits |
| cfg_init_gain | input | GAIN_W | Unmuted gain value |
| cfg_step | input | GAIN_W | Gain change per tick |
| cfg_presc | input | PRESC_W | Tick divider minus one |
| cfg_wait | input | WAIT_W | Hold time at zero minus one, in cycles |
| sw_set | input | 1 | Set the software mute request |
| sw_clr | input | 1 | Clear the software mute request |
| ext_evt | input | NUM_EVT-1 | External mute event lines |
| gain_out | output | GAIN_W | Gain to the multiplier |
| state_out | output | 2 | Sequencer state code |
| cause_out | output | NUM_EVT | Events that started the last mute |

## Verification
Two things can collide in one cycle: a new event during DEMUTE and a prescaler tick that would raise the gain. The bench provokes this by raising an external event while the ramp is climbing. It then checks that the state returns to MUTE and that the gain is held, not incremented. The same collision arises between an expired hold time and an event that is still high in WAIT. The bench keeps the software request set past the hold time and confirms that the block stays in WAIT. A behavioural model judges every cycle of both cases.

// File: rtl/automute_pkg.sv
package automute_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MUTE   = 2'd1,
        ST_WAIT   = 2'd2,
        ST_DEMUTE = 2'd3
    } mute_state_e;
endpackage

// File: rtl/automute_evt.sv
// Event gathering: sticky software request, masking, trigger OR.
module automute_evt #(
    parameter int NUM_EVT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_set,
    input  logic               sw_clr,
    input  logic [NUM_EVT-2:0] ext_evt,
    input  logic [NUM_EVT-1:0] mask,
    output logic [NUM_EVT-1:0] active,
    output logic               trig
);
    logic sw_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sw_q <= 1'b0;
        else if (sw_set) sw_q <= 1'b1;
        else if (sw_clr) sw_q <= 1'b0;
    end

    always_comb begin
        active = {ext_evt, sw_q} & ~mask;
        trig   = |active;
    end

    AST_SW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_set |=> sw_q); // R9
endmodule

// File: rtl/automute_tick.sv
// Free-running prescaler producing a one-cycle tick every cfg_presc+1 cycles.
module automute_tick #(
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PRESC_W-1:0] cfg_presc,
    output logic               tick
);
    logic [PRESC_W-1:0] cnt_q;

    assign tick = (cnt_q >= cfg_presc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    AST_TICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/automute_wait.sv
// Hold-time counter, cleared whenever the sequencer is not in WAIT.
module automute_wait #(
    parameter int WAIT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [WAIT_W-1:0] cfg_wait,
    output logic              done
);
    logic [WAIT_W-1:0] cnt_q;

    assign done = run && (cnt_q >= cfg_wait);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (!run)             cnt_q <= '0;
        else if (cnt_q < cfg_wait) cnt_q <= cnt_q + 1'b1;
    end

    AST_WAIT_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !$past(run)) |-> (cnt_q == '0)); // R5
endmodule

// File: rtl/automute_ctrl.sv
module automute_ctrl
    import automute_pkg::*;
#(
    parameter int NUM_EVT = 8,
    parameter int GAIN_W  = 12,
    parameter int PRESC_W = 8,
    parameter int WAIT_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_enable,
    input  logic [NUM_EVT-1:0] cfg_evt_mask,
    input  logic [GAIN_W-1:0]  cfg_init_gain,
    input  logic [GAIN_W-1:0]  cfg_step,
    input  logic [PRESC_W-1:0] cfg_presc,
    input  logic [WAIT_W-1:0]  cfg_wait,
    input  logic               sw_set,
    input  logic               sw_clr,
    input  logic [NUM_EVT-2:0] ext_evt,
    output logic [GAIN_W-1:0]  gain_out,
    output logic [1:0]         state_out,
    output logic [NUM_EVT-1:0] cause_out
);
    localparam int SUM_W = GAIN_W + 1;

    mute_state_e        state_q, state_d;
    logic [GAIN_W-1:0]  gain_q, gain_d;
    logic [NUM_EVT-1:0] cause_q, cause_d;
    logic [NUM_EVT-1:0] active;
    logic               trig, tick, wait_done;
    logic [SUM_W-1:0]   up_sum;

    automute_evt #(.NUM_EVT(NUM_EVT)) u_evt (
        .clk(clk), .rst_n(rst_n), .sw_set(sw_set), .sw_clr(sw_clr),
        .ext_evt(ext_evt), .mask(cfg_evt_mask), .active(active), .trig(trig)
    );

    automute_tick #(.PRESC_W(PRESC_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .cfg_presc(cfg_presc), .tick(tick)
    );

    automute_wait #(.WAIT_W(WAIT_W)) u_wait (
        .clk(clk), .rst_n(rst_n), .run(state_q == ST_WAIT),
        .cfg_wait(cfg_wait), .done(wait_done)
    );

    assign up_sum = {1'b0, gain_q} + {1'b0, cfg_step};

    // Next-state and ramp logic
    always_comb begin
        state_d = state_q;
        gain_d  = gain_q;
        cause_d = cause_q;
        if (!cfg_enable) begin
            state_d = ST_IDLE;
            gain_d  = cfg_init_gain;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    gain_d = cfg_init_gain;
                    if (trig) begin
                        state_d = ST_MUTE;
                        cause_d = active;
                    end
                end
                ST_MUTE: begin
                    if (tick) begin
                        if (gain_q <= cfg_step) begin
                            gain_d  = '0;
                            state_d = ST_WAIT;
                        end else begin
                            gain_d = gain_q - cfg_step;
                        end
                    end
                end
                ST_WAIT: begin
                    gain_d = '0;
                    if (wait_done && !trig) state_d = ST_DEMUTE;
                end
                ST_DEMUTE: begin
                    if (trig) begin
                        state_d = ST_MUTE;
                        cause_d = active;
                    end else if (tick) begin
                        if (up_sum >= {1'b0, cfg_init_gain}) begin
                            gain_d  = cfg_init_gain;
                            state_d = ST_IDLE;
                        end else begin
                            gain_d = up_sum[GAIN_W-1:0];
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            gain_q  <= '0;
            cause_q <= '0;
        end else begin
            state_q <= state_d;
            gain_q  <= gain_d;
            cause_q <= cause_d;
        end
    end

    // Outputs
    always_comb begin
        gain_out  = (state_q == ST_IDLE) ? cfg_init_gain : gain_q;
        state_out = state_q;
        cause_out = cause_q;
    end

    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> (state_q == ST_IDLE)); // R1
    AST_TRIG_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && trig && state_q == ST_IDLE) |=> (state_q == ST_MUTE)); // R3
    AST_MUTE_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && state_q == ST_MUTE) |=> (gain_q <= $past(gain_q))); // R4
    AST_WAIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> (gain_out == '0)); // R5
    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && trig && state_q == ST_WAIT) |=> (state_q == ST_WAIT)); // R5
    AST_ABORT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && trig && state_q == ST_DEMUTE)
        |=> (state_q == ST_MUTE && $stable(gain_q))); // R7
endmodule

// File: tb/automute_ctrl_test.sv
module automute_ctrl_test;
    localparam int NE = 8;
    localparam int GW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_enable = 1'b0;
    logic [NE-1:0] cfg_evt_mask = '0;
    logic [GW-1:0] cfg_init_gain = 12'd100;
    logic [GW-1:0] cfg_step = 12'd30;
    logic [7:0]    cfg_presc = 8'd2;
    logic [15:0]   cfg_wait = 16'd5;
    logic          sw_set = 1'b0, sw_clr = 1'b0;
    logic [NE-2:0] ext_evt = '0;
    logic [GW-1:0] gain_out;
    logic [1:0]    state_out;
    logic [NE-1:0] cause_out;

    int checks = 0, failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    automute_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_evt_mask(cfg_evt_mask),
        .cfg_init_gain(cfg_init_gain), .cfg_step(cfg_step), .cfg_presc(cfg_presc),
        .cfg_wait(cfg_wait), .sw_set(sw_set), .sw_clr(sw_clr), .ext_evt(ext_evt),
        .gain_out(gain_out), .state_out(state_out), .cause_out(cause_out)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    int m_state, m_gain, m_cause, m_cnt, m_w;
    bit m_sw;
    string st_tag[4] = '{"R3 idle", "R4 mute", "R5 wait", "R6 demute"};

    always @(posedge clk) begin
        int act, nxt_w;
        bit trig, tick, done;
        if (!rst_n) begin
            m_state = 0; m_gain = 0; m_cause = 0; m_cnt = 0; m_w = 0; m_sw = 0;
        end else begin
            act   = int'({ext_evt, m_sw} & ~cfg_evt_mask);
            trig  = (act != 0);
            tick  = (m_cnt >= int'(cfg_presc));
            m_cnt = tick ? 0 : m_cnt + 1;
            done  = (m_state == 2) && (m_w >= int'(cfg_wait));
            nxt_w = (m_state != 2) ? 0 : ((m_w < int'(cfg_wait)) ? m_w + 1 : m_w);
            m_w   = nxt_w;
            if (!cfg_enable) begin
                m_state = 0; m_gain = int'(cfg_init_gain);
            end else begin
                case (m_state)
                    0: begin
                        m_gain = int'(cfg_init_gain);
                        if (trig) begin m_state = 1; m_cause = act; end
                    end
                    1: if (tick) begin
                        if (m_gain <= int'(cfg_step)) begin m_gain = 0; m_state = 2; end
                        else m_gain -= int'(cfg_step);
                    end
                    2: begin
                        m_gain = 0;
                        if (done && !trig) m_state = 3;
                    end
                    default: begin
                        if (trig) begin m_state = 1; m_cause = act; end
                        else if (tick) begin
                            if (m_gain + int'(cfg_step) >= int'(cfg_init_gain)) begin
                                m_gain = int'(cfg_init_gain); m_state = 0;
                            end else m_gain += int'(cfg_step);
                        end
                    end
                endcase
            end
            if (sw_set) m_sw = 1; else if (sw_clr) m_sw = 0;
            #2;
            if (!finished) begin
                chk({"R11 state code in ", st_tag[m_state]}, int'(state_out), m_state);
                chk({st_tag[m_state], " gain"},
                    int'(gain_out), (m_state == 0) ? int'(cfg_init_gain) : m_gain);
                chk("R10 cause", int'(cause_out), m_cause);
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_state(int s, int limit, string tag);
        for (int i = 0; i < limit; i++) begin
            if (int'(state_out) == s) return;
            @(negedge clk);
        end
        chk(tag, int'(state_out), s);
    endtask

    initial begin
        int g;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk("R12 reset state", int'(state_out), 0);
        chk("R12 reset gain", int'(gain_out), 100);
        chk("R12 reset cause", int'(cause_out), 0);

        ext_evt[1] = 1'b1;
        cyc(15);
        chk("R1 disabled ignores events state", int'(state_out), 0);
        chk("R1 disabled gain", int'(gain_out), 100);

        cfg_evt_mask = 8'b0000_0100;
        cfg_enable = 1'b1;
        cyc(10);
        chk("R2 masked event ignored", int'(state_out), 0);

        ext_evt = '0; cfg_evt_mask = '0;
        sw_set = 1'b1; cyc(1); sw_set = 1'b0;
        chk("R9 request effective next clock", int'(state_out), 0);
        cyc(1);
        chk("R3 enters MUTE", int'(state_out), 1);
        chk("R10 cause software", int'(cause_out), 1);
        wait_state(2, 200, "R4 reaches WAIT");
        chk("R4 gain zero", int'(gain_out), 0);
        cyc(20);
        chk("R5 held by active event", int'(state_out), 2);
        sw_clr = 1'b1; cyc(1); sw_clr = 1'b0;
        cyc(1);
        chk("R5 leaves after clear", int'(state_out), 3);

        for (int i = 0; i < 50 && gain_out == 0; i++) cyc(1);
        g = int'(gain_out);
        ext_evt[0] = 1'b1;
        cyc(1);
        chk("R7 abort to MUTE", int'(state_out), 1);
        chk("R7 gain kept", int'(gain_out), g);
        chk("R10 cause external", int'(cause_out), 2);
        ext_evt = '0;
        wait_state(3, 300, "R6 demute reached");
        wait_state(0, 300, "R6 back to IDLE");
        chk("R6 final gain", int'(gain_out), 100);

        cfg_init_gain = 12'd5; cfg_step = 12'd1; cfg_presc = 8'd0;
        cyc(2);
        sw_set = 1'b1; cyc(1); sw_set = 1'b0;
        cyc(1);
        chk("R8 mute entered", int'(state_out), 1);
        cyc(4);
        chk("R8 tick every cycle gain", int'(gain_out), 1);
        cyc(1);
        chk("R8 WAIT after five ticks", int'(state_out), 2);
        cfg_enable = 1'b0;
        cyc(1);
        chk("R1 disable returns IDLE", int'(state_out), 0);
        chk("R1 disable gain", int'(gain_out), 5);

        sw_clr = 1'b1; cyc(1); sw_clr = 1'b0;
        cfg_init_gain = 12'd100; cfg_step = 12'd200; cfg_presc = 8'd3;
        cfg_enable = 1'b1;
        ext_evt[2] = 1'b1;
        wait_state(1, 10, "R4 saturating mute");
        wait_state(2, 10, "R4 one tick to zero");
        chk("R4 saturated gain", int'(gain_out), 0);
        ext_evt = '0;
        wait_state(0, 100, "R6 saturating demute");
        chk("R6 saturated gain", int'(gain_out), 100);
        cyc(3);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule